// File: doc/BRIEF.md
# Dual-Event Input Capture Unit

This unit timestamps activity on an external pin for a free-running timer. The pin passes through a two-flop synchroniser. Edges of the selected polarity are then detected, and on each qualifying edge the current counter value is stored in one of two capture slots. After the second capture the unit stops storing. It stays disarmed until software clears the capture count. Software picks whether the capture event strobe is raised after the first or after the second capture.

The unit holds its own copy of the capture-related control fields, loaded by a control-write strobe: edge mode, event-on-second and pin-as-input. A status write that sets the capture status bit reaches the unit as a single clear strobe. That decode is done by the surrounding register block. The counter itself and the interrupt logic live outside this unit.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset both capture registers read 0, `cap_event` is 0, edge mode is none (0), the pin direction is output (0) and the event-on-second bit is 0.
- R2: A pin change set up before rising clock edge k is captured at edge k+2. The stored value is `count_in` as presented just before edge k+2, which is the cycle in which the synchronised edge is detected.
- R3: Edge mode encoding on `ctrl_edge_mode`: 0 none (no capture ever), 1 rising edges only, 2 falling edges only, 3 both edges.
- R4: A capture happens only while the stored direction bit (`ctrl_dir_in` = 1 at the last control write) selects input. With it at 0, edges leave both capture registers unchanged.
- R5: After each arming, the first capture goes to `cap_first` and the second to `cap_second`. Later edges change neither register until the count is cleared.
- R6: With the event-on-second bit at 0, `cap_event` pulses high for exactly one cycle together with the first capture. With it at 1, the pulse comes with the second capture instead. It never pulses without a capture.
- R7: A one-cycle `stat_cap_clr` pulse (a status write with 1 at bit 2) resets the capture count to zero, so the next capture goes to `cap_first` again.
- R8: A control write clears the capture count when it moves the edge mode from none (0) to a non-zero mode. A control write that changes between two non-zero modes keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external capture pin |
| count_in | input | CNT_W | Running timer counter value |
| ctrl_wr | input | 1 | Control-write strobe; loads the three control fields below |
| ctrl_edge_mode | input | 2 | Edge mode for the write: 0 none, 1 rise, 2 fall, 3 both |
| ctrl_cap_second | input | 1 | 1: event on the second capture; 0: on the first |
| ctrl_dir_in | input | 1 | 1: pin used as input (captures allowed) |
| stat_cap_clr | input | 1 | Status write with the capture bit set; clears the capture count |
| cap_first | output | CNT_W | First capture register |
| cap_second | output | CNT_W | Second capture register |
| cap_event | output | 1 | One-cycle capture event strobe |

## Verification
The bench targets the points where a capture unit commonly slips.

- **Capture value.** The exact value stored two clocks after a pin change is checked. A design off by one synchroniser stage would store a neighbouring count.
- **Third edge.** A third edge after two captures is applied. A design with no saturation would overwrite a slot or wrap back to the first one.
- **Mode change without disarm.** The edge mode is switched from rising to falling without disarming. A design that cleared the count on every mode change would put that capture back into the first register.
- **Event point.** Both event-on-second settings are exercised. A swapped decode would pulse on the wrong capture.
- **Pin as output and mode none.** Edges are applied with the pin set as output and with mode none. Any register change at those times is flagged as an unexpected capture.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  localparam int CAP_SLOTS = 2;

  typedef struct packed {
    edge_mode_e mode;
    logic       on_second;
    logic       dir_in;
  } cap_cfg_t;
endpackage

// File: rtl/dcap_sync_edge.sv
module dcap_sync_edge
  import dcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       hit
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last;
  logic                   now;

  assign now = chain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[SYNC_STAGES-2:0], pin};
      last  <= now;
    end
  end

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = now & ~last;
      EDGE_FALL: hit = ~now & last;
      EDGE_BOTH: hit = now ^ last;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dcap_ctrl_regs.sv
module dcap_ctrl_regs
  import dcap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  cap_cfg_t cfg_new,
  output cap_cfg_t cfg_q,
  output logic     arm_clr
);
  // Leaving "none" re-arms the capture sequence.
  assign arm_clr = wr && (cfg_q.mode == EDGE_NONE) && (cfg_new.mode != EDGE_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{mode: EDGE_NONE, on_second: 1'b0, dir_in: 1'b0};
    end else if (wr) begin
      cfg_q <= cfg_new;
    end
  end
endmodule

// File: rtl/dcap_sequencer.sv
module dcap_sequencer
  import dcap_pkg::*;
#(
  parameter int CW = $clog2(CAP_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  cap_cfg_t             cfg,
  input  logic                 clr,
  output logic [CAP_SLOTS-1:0] slot_we,
  output logic [CW-1:0]        cnt_q,
  output logic                 event_q
);
  localparam logic [CW-1:0] FULL = CW'(CAP_SLOTS);
  localparam logic [CW-1:0] LAST = CW'(CAP_SLOTS - 1);

  logic take;
  logic fire;

  // A clear in the same cycle wins over an edge.
  assign take = hit && cfg.dir_in && (cnt_q < FULL) && !clr;
  assign fire = take && (cnt_q == (cfg.on_second ? LAST : '0));

  for (genvar i = 0; i < CAP_SLOTS; i++) begin : g_we
    assign slot_we[i] = take && (cnt_q == CW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      event_q <= 1'b0;
    end else begin
      event_q <= fire;
      if (clr)       cnt_q <= '0;
      else if (take) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dcap_capture_bank.sv
module dcap_capture_bank
  import dcap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [CAP_SLOTS-1:0]            we,
  input  logic [CNT_W-1:0]                count_in,
  output logic [CAP_SLOTS-1:0][CNT_W-1:0] slots
);
  for (genvar i = 0; i < CAP_SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)        slots[i] <= '0;
      else if (we[i]) slots[i] <= count_in;
    end
  end
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
  import dcap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic             ctrl_wr,
  input  logic [1:0]       ctrl_edge_mode,
  input  logic             ctrl_cap_second,
  input  logic             ctrl_dir_in,
  input  logic             stat_cap_clr,
  output logic [CNT_W-1:0] cap_first,
  output logic [CNT_W-1:0] cap_second,
  output logic             cap_event
);
  localparam int SEQ_CW = $clog2(CAP_SLOTS + 1);

  cap_cfg_t                        cfg_new, cfg_q;
  logic                            arm_clr, hit, cnt_clr;
  logic [CAP_SLOTS-1:0]            slot_we;
  logic [CAP_SLOTS-1:0][CNT_W-1:0] slots;
  logic [SEQ_CW-1:0]               cap_count;
  edge_mode_e                      cur_mode;
  logic                            cur_dir;

  assign cfg_new  = '{mode: edge_mode_e'(ctrl_edge_mode),
                      on_second: ctrl_cap_second, dir_in: ctrl_dir_in};
  assign cnt_clr  = arm_clr | stat_cap_clr;
  assign cur_mode = cfg_q.mode;
  assign cur_dir  = cfg_q.dir_in;

  dcap_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .cfg_new(cfg_new),
    .cfg_q(cfg_q), .arm_clr(arm_clr)
  );

  dcap_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(pin_in), .mode(cfg_q.mode), .hit(hit)
  );

  dcap_sequencer #(.CW(SEQ_CW)) u_seq (
    .clk(clk), .rst(rst), .hit(hit), .cfg(cfg_q), .clr(cnt_clr),
    .slot_we(slot_we), .cnt_q(cap_count), .event_q(cap_event)
  );

  dcap_capture_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .we(slot_we), .count_in(count_in), .slots(slots)
  );

  assign cap_first  = slots[0];
  assign cap_second = slots[1];
endmodule

// File: rtl/dcap_checker.sv
module dcap_checker
  import dcap_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CW    = 2
) (
  input logic             clk,
  input logic             rst,
  input edge_mode_e       mode_q,
  input logic             dir_q,
  input logic [CW-1:0]    cnt_q,
  input logic             clr_stat,
  input logic [CNT_W-1:0] cap1,
  input logic [CNT_W-1:0] cap2,
  input logic             ev
);
  p_event_single_r6: assert property (@(posedge clk) disable iff (rst)
    ev |=> !ev);

  p_event_with_capture_r6: assert property (@(posedge clk) disable iff (rst)
    ev |-> (!$stable(cap1) || !$stable(cap2)));

  p_dir_output_holds_r4: assert property (@(posedge clk) disable iff (rst)
    !dir_q |=> ($stable(cap1) && $stable(cap2)));

  p_mode_none_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == EDGE_NONE) |=> ($stable(cap1) && $stable(cap2)));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(CAP_SLOTS));

  p_full_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(CAP_SLOTS)) |=> ($stable(cap1) && $stable(cap2)));

  p_stat_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_stat |=> (cnt_q == '0));
endmodule

bind dual_capture_unit dcap_checker #(.CNT_W(CNT_W), .CW(SEQ_CW)) u_dcap_chk (
  .clk(clk), .rst(rst), .mode_q(cur_mode), .dir_q(cur_dir), .cnt_q(cap_count),
  .clr_stat(stat_cap_clr), .cap1(cap_first), .cap2(cap_second), .ev(cap_event)
);

// File: tb/tb_dual_capture_unit.sv
module tb_dual_capture_unit;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pin_in = 1'b0;
  logic [CW-1:0] count_in = '0;
  logic          ctrl_wr = 1'b0;
  logic [1:0]    ctrl_edge_mode = 2'd0;
  logic          ctrl_cap_second = 1'b0;
  logic          ctrl_dir_in = 1'b0;
  logic          stat_cap_clr = 1'b0;
  logic [CW-1:0] cap_first, cap_second;
  logic          cap_event;

  dual_capture_unit #(.CNT_W(CW)) dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) count_in <= count_in + 1;

  typedef struct {
    int            slot;
    logic [CW-1:0] val;
    logic          ev;
    string         req;
  } exp_t;

  exp_t          sbq[$];
  int            n_cmp = 0, n_bad = 0;
  logic          mon_on = 1'b0;
  logic [CW-1:0] last1, last2;

  // Reference model state
  int            m_cnt = 0, m_mode = 0;
  logic          m_sec = 1'b0, m_dir = 1'b0, m_pin = 1'b0;
  logic [CW-1:0] m_cap [2] = '{default: '0};

  task automatic check(input bit ok, input string req, input logic [CW-1:0] act,
                       input logic [CW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every register change or event pops one expected item
  always @(negedge clk) begin
    if (mon_on) begin
      bit ch1, ch2;
      ch1 = (cap_first != last1);
      ch2 = (cap_second != last2);
      if (ch1 || ch2 || cap_event) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R5 unexpected capture", {ch2, ch1, cap_event}, 0);
        end else begin
          exp_t e;
          int   act_slot;
          e = sbq.pop_front();
          act_slot = ch1 ? 0 : (ch2 ? 1 : -1);
          check(act_slot == e.slot, {e.req, " slot"}, act_slot, e.slot);
          check((e.slot == 0 ? cap_first : cap_second) == e.val,
                {e.req, " value"}, e.slot == 0 ? cap_first : cap_second, e.val);
          check(cap_event == e.ev, {e.req, " event"}, cap_event, e.ev);
        end
      end
      last1 = cap_first;
      last2 = cap_second;
    end
  end

  task automatic drive_pin(input logic v, input string req);
    bit hit;
    @(negedge clk);
    pin_in = v;
    case (m_mode)
      1: hit = !m_pin && v;
      2: hit = m_pin && !v;
      3: hit = (m_pin != v);
      default: hit = 1'b0;
    endcase
    m_pin = v;
    if (hit && m_dir && m_cnt < 2) begin
      exp_t e;
      e.slot = m_cnt;
      e.val  = count_in + 2;  // R2: two register stages before the capture edge
      e.ev   = (m_cnt == (m_sec ? 1 : 0));
      e.req  = req;
      m_cap[m_cnt] = e.val;
      sbq.push_back(e);
      m_cnt++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic ctrl_write(input int mode, input logic sec, input logic dir);
    @(negedge clk);
    ctrl_edge_mode = 2'(mode);
    ctrl_cap_second = sec;
    ctrl_dir_in = dir;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    if (m_mode == 0 && mode != 0) m_cnt = 0;  // R8
    m_mode = mode;
    m_sec = sec;
    m_dir = dir;
  endtask

  task automatic stat_clear();
    @(negedge clk);
    stat_cap_clr = 1'b1;
    @(negedge clk);
    stat_cap_clr = 1'b0;
    m_cnt = 0;  // R7
  endtask

  task automatic expect_regs(input string req);
    check(cap_first == m_cap[0], {req, " cap_first"}, cap_first, m_cap[0]);
    check(cap_second == m_cap[1], {req, " cap_second"}, cap_second, m_cap[1]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cap_first == 0, "R1 cap_first", cap_first, 0);
    check(cap_second == 0, "R1 cap_second", cap_second, 0);
    check(cap_event == 0, "R1 cap_event", cap_event, 0);
    last1 = cap_first;
    last2 = cap_second;
    mon_on = 1'b1;

    // R3: mode none at reset, edges ignored
    drive_pin(1'b1, "R3 none");
    drive_pin(1'b0, "R3 none");
    expect_regs("R3 none ignored");

    // Rising, event on first capture
    ctrl_write(1, 1'b0, 1'b1);
    drive_pin(1'b1, "R2 R6 first rise");
    drive_pin(1'b0, "R3 fall ignored in rise mode");
    expect_regs("R3 falling ignored");
    drive_pin(1'b1, "R5 second rise");
    drive_pin(1'b0, "R5");
    drive_pin(1'b1, "R5 third edge");
    expect_regs("R5 third edge ignored");

    // R7: status clear re-arms
    stat_clear();
    drive_pin(1'b0, "R7");
    drive_pin(1'b1, "R7 after clear");
    expect_regs("R7 first slot again");

    // R8: rise -> fall keeps count (1); event on second
    ctrl_write(2, 1'b1, 1'b1);
    drive_pin(1'b0, "R8 no clear between modes");
    drive_pin(1'b1, "R5 full");
    drive_pin(1'b0, "R5 full");
    expect_regs("R8 R5 held");

    // R3 none, then R8 none -> both clears
    ctrl_write(0, 1'b1, 1'b1);
    drive_pin(1'b1, "R3 none");
    drive_pin(1'b0, "R3 none");
    expect_regs("R3 none held");
    ctrl_write(3, 1'b1, 1'b1);
    drive_pin(1'b1, "R8 R6 both first no event");
    drive_pin(1'b0, "R6 both second event");
    expect_regs("R3 both edges");

    // R4: pin as output blocks captures
    stat_clear();
    ctrl_write(3, 1'b1, 1'b0);
    drive_pin(1'b1, "R4 output");
    drive_pin(1'b0, "R4 output");
    expect_regs("R4 output held");
    ctrl_write(3, 1'b1, 1'b1);
    drive_pin(1'b1, "R4 input again");
    expect_regs("R4 capture resumes");

    repeat (6) @(negedge clk);
    check(sbq.size() == 0, "R5 R6 pending expected captures", sbq.size(), 0);
    finish_run();
  end
endmodule